// File: doc/BRIEF.md
# Link Training Speed Fallback Controller

This block decides, once per request, whether a serial link has reached its operational state. It compares a 6-bit training-state code against the operational threshold. When the first comparison fails, it issues a write that forces the speed field of the link capability word down to first generation. It then waits a programmable settle time and compares again. If the link is still not up, it writes the capability word that was sampled at the start back unchanged and reports that the link is down.

A start pulse launches the sequence. A one-cycle done pulse ends it, and two flags, link up and fallback used, hold the result until the next start. The capability word goes out as a write strobe plus data, and the surrounding register logic applies it. A small combinational decoder splits the link status word into the negotiated lane width and the current speed.

The controller has seven states. `ST_IDLE` waits for start. `ST_CHECK1` makes the first judgement. `ST_LOWER` issues the generation-1 write. `ST_SETTLE` counts out the settle interval. `ST_CHECK2` makes the second judgement. `ST_RESTORE` writes the original word back. `ST_FINISH` raises done. The transitions are:

- `ST_IDLE` to `ST_CHECK1` on start.
- `ST_CHECK1` to `ST_FINISH` when the link is up, otherwise to `ST_LOWER`.
- `ST_LOWER` to `ST_SETTLE`, always.
- `ST_SETTLE` to `ST_CHECK2` when the timer expires.
- `ST_CHECK2` to `ST_FINISH` when the link is up, otherwise to `ST_RESTORE`.
- `ST_RESTORE` to `ST_FINISH`, always.
- `ST_FINISH` to `ST_IDLE`, always.

Top module: `lk_fallback_ctrl`

## Requirements
- R1: After reset, done, cap_wr_en, busy, link_up and fallback_used are all 0.
- R2: A training-state code of 0x11 or higher counts as link up, and a code below 0x11 counts as not up. The code 0x10 fails and the codes 0x11 and 0x3F pass.
- R3: If the first check passes, done pulses 2 cycles after the clock edge that samples start, with link_up=1 and fallback_used=0, and no capability write occurs.
- R4: If the first check fails, exactly one write is issued 2 cycles after the start edge. Its data is the sampled capability word with bits 3:0 replaced by 1 and bits 31:4 unchanged.
- R5: The second check is made exactly SETTLE_CYCLES cycles after the lowering write ends.
- R6: If the second check passes, done pulses with link_up=1 and fallback_used=1, and no further write occurs.
- R7: If the second check fails, the sampled capability word is written back unchanged. Done follows one cycle later with link_up=0 and fallback_used=1.
- R8: Done lasts one cycle. link_up and fallback_used keep their values after done until the next accepted start.
- R9: A start pulse while busy is ignored. It produces no extra write or done, and it does not change the sampled capability word.
- R10: The capability word is sampled on the start edge. Later changes on cap_in do not affect either write.
- R11: neg_width equals link_status bits 9:4 and neg_speed equals link_status bits 3:0, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| train_state | input | 6 | Current training-state code |
| cap_in | input | 32 | Current link capability word |
| link_status | input | 16 | Link status word to decode |
| cap_wr_en | output | 1 | Capability write strobe |
| cap_wr_data | output | 32 | Capability write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| link_up | output | 1 | Result: link operational |
| fallback_used | output | 1 | Result: speed fallback was attempted |
| neg_width | output | 6 | Negotiated lane width |
| neg_speed | output | 4 | Current link speed |

## Verification
Counted from the clock edge that samples start, the outputs fall due as follows:

- A quick pass raises done at +2.
- The lowering write appears at +2.
- A pass on the second check raises done at +4+SETTLE_CYCLES.
- A failure on the second check puts the restore write at +4+SETTLE_CYCLES and done at +5+SETTLE_CYCLES.

The driver records the cycle of the start edge and pushes each expected write and done, each with its absolute due cycle, into a queue. The monitor samples on the falling edge, pops one item for every write or done it observes, and compares the kind, the data, the flags and the cycle. An event that arrives when the queue is empty counts as a failure, and so does a queue that has not drained.

// File: rtl/lk_pkg.sv
package lk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK1,
        ST_LOWER,
        ST_SETTLE,
        ST_CHECK2,
        ST_RESTORE,
        ST_FINISH
    } lk_state_e;

    localparam int unsigned LK_CODE_W   = 6;
    localparam int unsigned LK_CAP_W    = 32;
    localparam int unsigned LK_SPEED_W  = 4;
    localparam int unsigned LK_STAT_W   = 16;
    localparam int unsigned LK_WIDTH_W  = 6;

endpackage

// File: rtl/lk_state_judge.sv
module lk_state_judge #(
    parameter int unsigned CODE_W  = 6,
    parameter logic [CODE_W-1:0] UP_CODE = 6'h11
) (
    input  logic [CODE_W-1:0] code,
    output logic              is_up
);
    // Any code at or beyond the operational threshold counts as up.
    always_comb begin
        is_up = (code >= UP_CODE);
    end
endmodule

// File: rtl/lk_cap_rewrite.sv
module lk_cap_rewrite #(
    parameter int unsigned CAP_W   = 32,
    parameter int unsigned SPEED_W = 4,
    parameter int unsigned FB_SPEED = 1
) (
    input  logic [CAP_W-1:0] cap_orig,
    output logic [CAP_W-1:0] cap_low
);
    localparam logic [SPEED_W-1:0] FB_FIELD = SPEED_W'(FB_SPEED);

    // Replace only the maximum-speed field; keep the rest of the word.
    always_comb begin
        cap_low = cap_orig;
        cap_low[SPEED_W-1:0] = FB_FIELD;
    end
endmodule

// File: rtl/lk_settle_timer.sv
module lk_settle_timer #(
    parameter int unsigned CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        expired = (cnt_q == '0);
    end
endmodule

// File: rtl/lk_status_decode.sv
module lk_status_decode #(
    parameter int unsigned STAT_W    = 16,
    parameter int unsigned WIDTH_LSB = 4,
    parameter int unsigned WIDTH_W   = 6,
    parameter int unsigned SPEED_W   = 4
) (
    input  logic [STAT_W-1:0]  status,
    output logic [WIDTH_W-1:0] width,
    output logic [SPEED_W-1:0] speed
);
    always_comb begin
        width = status[WIDTH_LSB +: WIDTH_W];
        speed = status[SPEED_W-1:0];
    end
endmodule

// File: rtl/lk_fallback_ctrl.sv
module lk_fallback_ctrl
    import lk_pkg::*;
#(
    parameter int unsigned CODE_W        = LK_CODE_W,
    parameter logic [CODE_W-1:0] UP_CODE = 6'h11,
    parameter int unsigned CAP_W         = LK_CAP_W,
    parameter int unsigned SPEED_W       = LK_SPEED_W,
    parameter int unsigned FB_SPEED      = 1,
    parameter int unsigned STAT_W        = LK_STAT_W,
    parameter int unsigned WIDTH_W       = LK_WIDTH_W,
    parameter int unsigned SETTLE_CYCLES = 12_500_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CODE_W-1:0]  train_state,
    input  logic [CAP_W-1:0]   cap_in,
    input  logic [STAT_W-1:0]  link_status,
    output logic               cap_wr_en,
    output logic [CAP_W-1:0]   cap_wr_data,
    output logic               busy,
    output logic               done,
    output logic               link_up,
    output logic               fallback_used,
    output logic [WIDTH_W-1:0] neg_width,
    output logic [SPEED_W-1:0] neg_speed
);
    localparam int unsigned WIDTH_LSB = SPEED_W;

    lk_state_e        state_q, state_d;
    logic [CAP_W-1:0] cap_saved_q;
    logic [CAP_W-1:0] cap_lowered;
    logic             code_up;
    logic             tmr_load, tmr_run, tmr_expired;
    logic             accept;

    lk_state_judge #(.CODE_W(CODE_W), .UP_CODE(UP_CODE)) u_judge (
        .code  (train_state),
        .is_up (code_up)
    );

    lk_cap_rewrite #(.CAP_W(CAP_W), .SPEED_W(SPEED_W), .FB_SPEED(FB_SPEED)) u_rewrite (
        .cap_orig (cap_saved_q),
        .cap_low  (cap_lowered)
    );

    lk_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    lk_status_decode #(
        .STAT_W(STAT_W), .WIDTH_LSB(WIDTH_LSB), .WIDTH_W(WIDTH_W), .SPEED_W(SPEED_W)
    ) u_decode (
        .status (link_status),
        .width  (neg_width),
        .speed  (neg_speed)
    );

    assign accept   = (state_q == ST_IDLE) && start;
    assign tmr_load = (state_q == ST_LOWER);
    assign tmr_run  = (state_q == ST_SETTLE);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CHECK1;
            ST_CHECK1:  state_d = code_up ? ST_FINISH : ST_LOWER;
            ST_LOWER:   state_d = ST_SETTLE;
            ST_SETTLE:  if (tmr_expired) state_d = ST_CHECK2;
            ST_CHECK2:  state_d = code_up ? ST_FINISH : ST_RESTORE;
            ST_RESTORE: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register, sampled capability word and held result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            cap_saved_q   <= '0;
            link_up       <= 1'b0;
            fallback_used <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cap_saved_q   <= cap_in;
                link_up       <= 1'b0;
                fallback_used <= 1'b0;
            end
            if ((state_q == ST_CHECK1 || state_q == ST_CHECK2) && code_up) begin
                link_up <= 1'b1;
            end
            if (state_q == ST_LOWER) begin
                fallback_used <= 1'b1;
            end
        end
    end

    // Moore outputs.
    always_comb begin
        cap_wr_en   = 1'b0;
        cap_wr_data = '0;
        done        = 1'b0;
        busy        = (state_q != ST_IDLE);
        unique case (state_q)
            ST_LOWER: begin
                cap_wr_en   = 1'b1;
                cap_wr_data = cap_lowered;
            end
            ST_RESTORE: begin
                cap_wr_en   = 1'b1;
                cap_wr_data = cap_saved_q;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lk_fallback_chk.sv
module lk_fallback_chk
    import lk_pkg::*;
#(
    parameter int unsigned CODE_W        = 6,
    parameter logic [CODE_W-1:0] UP_CODE = 6'h11,
    parameter int unsigned CAP_W         = 32,
    parameter int unsigned SPEED_W       = 4,
    parameter int unsigned SETTLE_CYCLES = 12_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] train_state,
    input  logic [CAP_W-1:0]  cap_in,
    input  logic              cap_wr_en,
    input  logic [CAP_W-1:0]  cap_wr_data,
    input  logic              done,
    input  logic              link_up,
    input  logic              fallback_used,
    input  lk_state_e         state
);
    logic [CAP_W-1:0] ref_cap_q;
    logic [31:0]      settle_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cap_q    <= '0;
            settle_cnt_q <= '0;
        end else begin
            if (state == ST_IDLE && start) ref_cap_q <= cap_in;
            settle_cnt_q <= (state == ST_SETTLE) ? settle_cnt_q + 1 : 32'd0;
        end
    end

    AST_FAST_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK1 && train_state >= UP_CODE) |=> (done && link_up && !fallback_used)); // R3

    AST_LOWER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOWER) |-> (cap_wr_en && cap_wr_data[CAP_W-1:SPEED_W] == ref_cap_q[CAP_W-1:SPEED_W]
                                  && cap_wr_data[SPEED_W-1:0] == SPEED_W'(1))); // R4

    AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK2) |-> (settle_cnt_q == 32'(SETTLE_CYCLES))); // R5

    AST_RESTORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESTORE) |-> (cap_wr_en && cap_wr_data == ref_cap_q)); // R7

    AST_DOWN_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !link_up) |-> ($past(cap_wr_en) && fallback_used)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && start) |=> (state == ST_SETTLE || state == ST_CHECK2)); // R9
endmodule

bind lk_fallback_ctrl lk_fallback_chk #(
    .CODE_W(CODE_W), .UP_CODE(UP_CODE), .CAP_W(CAP_W),
    .SPEED_W(SPEED_W), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .train_state(train_state),
    .cap_in(cap_in), .cap_wr_en(cap_wr_en), .cap_wr_data(cap_wr_data),
    .done(done), .link_up(link_up), .fallback_used(fallback_used),
    .state(state_q)
);

// File: tb/tb_lk_fallback_ctrl.sv
module tb_lk_fallback_ctrl;
    localparam int unsigned N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  train_state = '0;
    logic [31:0] cap_in = '0;
    logic [15:0] link_status = '0;
    logic        cap_wr_en, busy, done, link_up, fallback_used;
    logic [31:0] cap_wr_data;
    logic [5:0]  neg_width;
    logic [3:0]  neg_speed;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wd = 0;

    typedef struct {
        bit          is_done;
        logic [31:0] data;
        bit          up;
        bit          fb;
        int          due;
        string       req;
    } exp_t;
    exp_t q[$];

    lk_fallback_ctrl #(.SETTLE_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .train_state(train_state),
        .cap_in(cap_in), .link_status(link_status), .cap_wr_en(cap_wr_en),
        .cap_wr_data(cap_wr_data), .busy(busy), .done(done), .link_up(link_up),
        .fallback_used(fallback_used), .neg_width(neg_width), .neg_speed(neg_speed)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pop one expected item per observed event.
    always @(negedge clk) begin
        if (rst_n && (cap_wr_en || done)) begin
            if (q.size() == 0) begin
                check(0, "R9", "unexpected event", {cap_wr_en, done}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.is_done == done && e.is_done != cap_wr_en, e.req, "event kind",
                      {cap_wr_en, done}, {!e.is_done, e.is_done});
                check(cyc == e.due, e.req, "event cycle", cyc, e.due);
                if (e.is_done) begin
                    check(link_up == e.up, e.req, "link_up", link_up, e.up);
                    check(fallback_used == e.fb, e.req, "fallback_used", fallback_used, e.fb);
                end else begin
                    check(cap_wr_data == e.data, e.req, "write data", cap_wr_data, e.data);
                end
            end
        end
    end

    // Driver: push expectations derived from the requirements, then stimulate.
    task automatic run_op(input logic [31:0] cap, input logic [5:0] s1,
                          input logic [5:0] s2, input bit poke_busy);
        int t0;
        bit up1, up2;
        up1 = (s1 >= 6'h11);
        up2 = (s2 >= 6'h11);
        @(negedge clk);
        t0 = cyc;
        if (up1) begin
            q.push_back('{1, 0, 1, 0, t0 + 2, "R3"});
        end else begin
            q.push_back('{0, {cap[31:4], 4'h1}, 0, 0, t0 + 2, "R4"});
            if (up2) begin
                q.push_back('{1, 0, 1, 1, t0 + 4 + N, "R6"});
            end else begin
                q.push_back('{0, cap, 0, 0, t0 + 4 + N, "R7"});
                q.push_back('{1, 0, 0, 1, t0 + 5 + N, "R7"});
            end
        end
        start = 1'b1; train_state = s1; cap_in = cap;
        @(negedge clk); start = 1'b0;
        @(negedge clk); train_state = s2; cap_in = ~cap; // R10: later cap changes ignored
        if (poke_busy) begin
            @(negedge clk); start = 1'b1; cap_in = 32'h0BAD_F00D;
            @(negedge clk); start = 1'b0;
        end
        for (int i = 0; i < 100 && q.size() != 0; i++) @(negedge clk);
        check(q.size() == 0, "R5", "queue drained", q.size(), 0);
        repeat (3) @(negedge clk);
        check(!done && link_up == (up1 || up2) && fallback_used == !up1, "R8",
              "held flags", {done, link_up, fallback_used}, {1'b0, up1 || up2, !up1});
        q.delete();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 200000) begin
                check(0, "WD", "watchdog", wd, 0);
                report();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !cap_wr_en && !busy && !link_up && !fallback_used, "R1",
              "reset outputs", {done, cap_wr_en, busy, link_up, fallback_used}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !cap_wr_en && !busy, "R1", "after release",
              {done, cap_wr_en, busy}, 0);

        run_op(32'hA5C3_0F03, 6'h11, 6'h11, 0); // R2 threshold passes
        run_op(32'h1234_5673, 6'h3F, 6'h00, 0); // R2 max code passes
        run_op(32'hFFFF_FFF3, 6'h10, 6'h11, 0); // R2 0x10 fails, recheck ok (R6)
        run_op(32'h0000_0002, 6'h00, 6'h10, 0); // R7 restore path
        run_op(32'hCAFE_BEE4, 6'h05, 6'h22, 1); // R9 start while busy
        run_op(32'h8765_4320, 6'h0F, 6'h0F, 1); // R9 + R7

        link_status = 16'h0123; #1;
        check(neg_width == 6'h12 && neg_speed == 4'h3, "R11", "decode a",
              {neg_width, neg_speed}, {6'h12, 4'h3});
        link_status = 16'hFC3F; #1;
        check(neg_width == 6'h03 && neg_speed == 4'hF, "R11", "decode b",
              {neg_width, neg_speed}, {6'h03, 4'hF});
        link_status = 16'h03F0; #1;
        check(neg_width == 6'h3F && neg_speed == 4'h0, "R11", "decode c",
              {neg_width, neg_speed}, {6'h3F, 4'h0});

        report();
    end
endmodule